// File: doc/BRIEF.md
# LPC Peripheral Target Responder

This block sits on the peripheral side of a Low Pin Count bus. It samples the 4-bit multiplexed address/data lines and the frame strobe on every clock. From them it decodes the host's cycle header, which is a start code, a cycle-type nibble, address or channel nibbles, and a size nibble. It also takes in any write data the host sends. Once the host has turned the bus around, the block drives SYNC, read data and its own turnaround, together with an output enable for an external tri-state pad.

The local side is a level request/acknowledge port. During the SYNC phase the block raises `regReq` and presents the decoded address, cycle kind, direction, size and write data. It sends long-wait SYNC until `regAck` is sampled high. For reads, `regRdata` is captured on that same clock. Four cycle families are handled: I/O, memory, firmware and DMA. Their header layouts differ, and the DMA direction bit has the opposite sense to the I/O and memory one.

Top module: `lpcTarget`

## Requirements
- R1: While `rstN` is low, and on the first clock after it rises, `ladOe` and `regReq` are low.
- R2: With `frameIn` high and LAD = 0000, the next nibble selects the cycle. 0000 is an I/O read and 0010 is an I/O write. Four address nibbles follow, most significant first. `regAddr` holds the 16-bit address zero-extended, `regKind` = 0, `regSize` = 0 (one byte).
- R3: Cycle nibble 0100 (memory read) or 0110 (memory write) is followed by eight address nibbles, most significant first. `regAddr` holds all 32 bits, `regKind` = 1, `regSize` = 0.
- R4: Start code 1101 (firmware read) or 1110 (firmware write) is followed directly by eight address nibbles and then a size nibble; there is no cycle-type nibble. Size 0, 1 and 2 give `regSize` 0, 1 and 2 (1, 2 and 4 bytes). `regKind` = 2.
- R5: Cycle nibble 1000 is a DMA transfer into the target (`regWrite` = 1) and 1010 is a DMA transfer out of it (`regWrite` = 0). The next nibble is {terminal count, channel[2:0]} and appears on `dmaTc`/`dmaChan`. A size nibble follows: 0, 1 and 3 give `regSize` 0, 1 and 2. `regKind` = 3, `regAddr` = 0, and `regSize` is never 3.
- R6: Host write data arrives low nibble first, byte 0 first, and is placed in `regWdata` at its byte and nibble position.
- R7: `ladOe` stays low through the whole host header and the two host turnaround clocks. The first driven clock is the third one after the last host nibble, and it carries long-wait SYNC.
- R8: `regReq` is high from the first driven clock until `regAck` is sampled high. While `regReq` is high, LAD carries 0110. On the clock after the acknowledge, LAD carries ready SYNC 0000 and `regReq` is low.
- R9: For reads, the data captured at the acknowledge follows ready SYNC, low nibble first and byte 0 first. In a multi-byte DMA read, one extra ready SYNC clock precedes every byte after the first.
- R10: The cycle ends with one clock of 1111 driven and then one clock with `ladOe` low. A start code presented on that last clock is accepted.
- R11: `frameIn` sampled high at any point in a transaction aborts it. On the next clock `ladOe` and `regReq` are low, and the nibble is decoded as a new start code.
- R12: An unknown start code, or an unknown cycle-type nibble, returns the block to idle. No request is raised and LAD is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameIn | input | 1 | Frame strobe, active high |
| ladIn | input | 4 | LAD lines as sampled from the pad |
| ladOut | output | 4 | Nibble to drive onto LAD |
| ladOe | output | 1 | Pad output enable for LAD |
| regReq | output | 1 | Local access request, held until acknowledged |
| regWrite | output | 1 | 1 = data flows into the target |
| regKind | output | 2 | 0 I/O, 1 memory, 2 firmware, 3 DMA |
| regAddr | output | 32 | Decoded address |
| regSize | output | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| regWdata | output | 32 | Write data gathered from the host |
| regRdata | input | 32 | Read data, captured with the acknowledge |
| regAck | input | 1 | Local access acknowledge |
| dmaChan | output | 3 | DMA channel number |
| dmaTc | output | 1 | DMA terminal count flag |

## Verification
Two functions can fall on the same clock. First, the frame-strobe abort can arrive while the target is driving long-wait SYNC with its request outstanding. The bench raises the frame strobe with a new start code in the middle of a pending memory read. It then expects LAD released and the request dropped one clock later, and the following I/O write to decode correctly. Second, the final turnaround clock can meet the next start code. The vector loop presents each new start on the exact clock where the previous cycle releases LAD, and it judges the result by the address and kind decoded for the new cycle.

// File: rtl/lpcTgtPkg.sv
package lpcTgtPkg;

  // start and cycle-type codes seen on LAD
  localparam logic [3:0] LAD_START  = 4'h0;
  localparam logic [3:0] LAD_FW_RD  = 4'hD;
  localparam logic [3:0] LAD_FW_WR  = 4'hE;
  localparam logic [3:0] CT_IO_RD   = 4'h0;
  localparam logic [3:0] CT_IO_WR   = 4'h2;
  localparam logic [3:0] CT_MEM_RD  = 4'h4;
  localparam logic [3:0] CT_MEM_WR  = 4'h6;
  localparam logic [3:0] CT_DMA_IN  = 4'h8;
  localparam logic [3:0] CT_DMA_OUT = 4'hA;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_LONG  = 4'h6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CYC, ST_ADDR, ST_CHAN, ST_SIZE, ST_HDATA, ST_HTAR1,
    ST_HTAR2, ST_SWAIT, ST_SOK, ST_RDATA, ST_PTAR1, ST_PTAR2
  } stateT;

  typedef enum logic [1:0] { K_IO, K_MEM, K_FW, K_DMA } kindT;

  typedef enum logic [2:0] { DRV_NONE, DRV_WAIT, DRV_READY, DRV_DATA, DRV_ONES } drvT;

  typedef struct packed {
    logic clear;
    logic addrShift;
    logic wdShift;
    logic chanLoad;
    logic sizeLoad;
    logic rdLoad;
    drvT  drv;
  } strobeT;

endpackage

// File: rtl/lpcTgtCtrl.sv
module lpcTgtCtrl
  import lpcTgtPkg::*;
#(
  parameter int IO_NIBS  = 4,
  parameter int MEM_NIBS = 8,
  parameter int SEL_W    = 3,
  localparam int CNT_W   = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameIn,
  input  logic [3:0]       ladIn,
  input  logic [1:0]       sizeCode,
  input  logic             regAck,
  output strobeT           strb,
  output logic [SEL_W-1:0] nibIdx,
  output kindT             kind,
  output logic             isWrite,
  output logic             regReq
);

  stateT            state, nState;
  kindT             nKind;
  logic             nWr;
  logic [CNT_W-1:0] cnt, nCnt;
  logic [CNT_W-1:0] lastData, lastAddr;

  assign lastData = (CNT_W'(2) << sizeCode) - CNT_W'(1);
  assign lastAddr = (kind == K_IO) ? CNT_W'(IO_NIBS - 1) : CNT_W'(MEM_NIBS - 1);
  assign nibIdx   = cnt[SEL_W-1:0];
  assign regReq   = (state == ST_SWAIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kind    <= K_IO;
      isWrite <= 1'b0;
      cnt     <= '0;
    end else begin
      state   <= nState;
      kind    <= nKind;
      isWrite <= nWr;
      cnt     <= nCnt;
    end
  end

  always_comb begin
    nState = state;
    nKind  = kind;
    nWr    = isWrite;
    nCnt   = cnt;
    strb   = '0;
    unique case (state)
      ST_SWAIT: strb.drv = DRV_WAIT;
      ST_SOK:   strb.drv = DRV_READY;
      ST_RDATA: strb.drv = DRV_DATA;
      ST_PTAR1: strb.drv = DRV_ONES;
      default:  strb.drv = DRV_NONE;
    endcase

    if (frameIn) begin
      // a frame strobe always wins: abort and decode a fresh start
      strb.clear = 1'b1;
      nCnt       = '0;
      unique case (ladIn)
        LAD_START: nState = ST_CYC;
        LAD_FW_RD: begin nState = ST_ADDR; nKind = K_FW; nWr = 1'b0; end
        LAD_FW_WR: begin nState = ST_ADDR; nKind = K_FW; nWr = 1'b1; end
        default:   nState = ST_IDLE;
      endcase
    end else begin
      unique case (state)
        ST_CYC: begin
          nCnt = '0;
          unique case (ladIn)
            CT_IO_RD:   begin nState = ST_ADDR; nKind = K_IO;  nWr = 1'b0; end
            CT_IO_WR:   begin nState = ST_ADDR; nKind = K_IO;  nWr = 1'b1; end
            CT_MEM_RD:  begin nState = ST_ADDR; nKind = K_MEM; nWr = 1'b0; end
            CT_MEM_WR:  begin nState = ST_ADDR; nKind = K_MEM; nWr = 1'b1; end
            CT_DMA_IN:  begin nState = ST_CHAN; nKind = K_DMA; nWr = 1'b1; end
            CT_DMA_OUT: begin nState = ST_CHAN; nKind = K_DMA; nWr = 1'b0; end
            default:    nState = ST_IDLE;
          endcase
        end
        ST_ADDR: begin
          strb.addrShift = 1'b1;
          nCnt = cnt + CNT_W'(1);
          if (cnt == lastAddr) begin
            nCnt = '0;
            if (kind == K_FW) nState = ST_SIZE;
            else              nState = isWrite ? ST_HDATA : ST_HTAR1;
          end
        end
        ST_CHAN: begin
          strb.chanLoad = 1'b1;
          nState = ST_SIZE;
        end
        ST_SIZE: begin
          strb.sizeLoad = 1'b1;
          nCnt   = '0;
          nState = isWrite ? ST_HDATA : ST_HTAR1;
        end
        ST_HDATA: begin
          strb.wdShift = 1'b1;
          nCnt = cnt + CNT_W'(1);
          if (cnt == lastData) begin
            nCnt   = '0;
            nState = ST_HTAR1;
          end
        end
        ST_HTAR1: nState = ST_HTAR2;
        ST_HTAR2: nState = ST_SWAIT;
        ST_SWAIT: begin
          if (regAck) begin
            strb.rdLoad = 1'b1;
            nState = ST_SOK;
          end
        end
        ST_SOK: nState = isWrite ? ST_PTAR1 : ST_RDATA;
        ST_RDATA: begin
          nCnt = cnt + CNT_W'(1);
          if (cnt == lastData) begin
            nCnt   = '0;
            nState = ST_PTAR1;
          end else if (cnt[0] && kind == K_DMA) begin
            nState = ST_SOK;
          end
        end
        ST_PTAR1: nState = ST_PTAR2;
        ST_PTAR2: nState = ST_IDLE;
        default:  nState = ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lpcTgtDatapath.sv
module lpcTgtDatapath
  import lpcTgtPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 3,
  localparam int NIBS  = DATA_W / 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        ladIn,
  input  strobeT            strb,
  input  logic [SEL_W-1:0]  nibIdx,
  input  kindT              kind,
  input  logic [DATA_W-1:0] regRdata,
  output logic [3:0]        ladOut,
  output logic              ladOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic [1:0]        sizeCode,
  output logic [2:0]        dmaChan,
  output logic              dmaTc
);

  logic [DATA_W-1:0] rdata;
  logic [1:0]        sizeDec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               regAddr <= '0;
    else if (strb.clear)     regAddr <= '0;
    else if (strb.addrShift) regAddr <= {regAddr[ADDR_W-5:0], ladIn};
  end

  // one register lane per nibble of write data
  for (genvar g = 0; g < NIBS; g++) begin : gWdLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regWdata[4*g +: 4] <= 4'h0;
      else if (strb.clear)
        regWdata[4*g +: 4] <= 4'h0;
      else if (strb.wdShift && nibIdx == SEL_W'(g))
        regWdata[4*g +: 4] <= ladIn;
    end
  end

  always_comb begin
    unique case (ladIn)
      4'h0:    sizeDec = 2'd0;
      4'h1:    sizeDec = 2'd1;
      4'h2:    sizeDec = (kind == K_FW)  ? 2'd2 : 2'd0;
      4'h3:    sizeDec = (kind == K_DMA) ? 2'd2 : 2'd0;
      default: sizeDec = 2'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeCode <= 2'd0;
      dmaChan  <= 3'd0;
      dmaTc    <= 1'b0;
      rdata    <= '0;
    end else begin
      if (strb.clear) begin
        sizeCode <= 2'd0;
        dmaChan  <= 3'd0;
        dmaTc    <= 1'b0;
      end else begin
        if (strb.sizeLoad) sizeCode <= sizeDec;
        if (strb.chanLoad) {dmaTc, dmaChan} <= ladIn;
      end
      if (strb.rdLoad) rdata <= regRdata;
    end
  end

  always_comb begin
    ladOe = (strb.drv != DRV_NONE);
    unique case (strb.drv)
      DRV_WAIT:  ladOut = SYNC_LONG;
      DRV_READY: ladOut = SYNC_READY;
      DRV_DATA:  ladOut = rdata[{nibIdx, 2'b00} +: 4];
      DRV_ONES:  ladOut = 4'hF;
      default:   ladOut = 4'h0;
    endcase
  end

endmodule

// File: rtl/lpcTarget.sv
module lpcTarget
  import lpcTgtPkg::*;
#(
  parameter int DATA_BYTES = 4,
  parameter int IO_NIBS    = 4,
  parameter int MEM_NIBS   = 8,
  localparam int DATA_W    = 8 * DATA_BYTES,
  localparam int ADDR_W    = 4 * MEM_NIBS,
  localparam int SEL_W     = $clog2(2 * DATA_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameIn,
  input  logic [3:0]        ladIn,
  output logic [3:0]        ladOut,
  output logic              ladOe,
  output logic              regReq,
  output logic              regWrite,
  output logic [1:0]        regKind,
  output logic [ADDR_W-1:0] regAddr,
  output logic [1:0]        regSize,
  output logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] regRdata,
  input  logic              regAck,
  output logic [2:0]        dmaChan,
  output logic              dmaTc
);

  strobeT           strb;
  logic [SEL_W-1:0] nibIdx;
  kindT             kind;

  assign regKind = kind;

  lpcTgtCtrl #(.IO_NIBS(IO_NIBS), .MEM_NIBS(MEM_NIBS), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .frameIn(frameIn), .ladIn(ladIn),
    .sizeCode(regSize), .regAck(regAck), .strb(strb), .nibIdx(nibIdx),
    .kind(kind), .isWrite(regWrite), .regReq(regReq)
  );

  lpcTgtDatapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) uDp (
    .clk(clk), .rstN(rstN), .ladIn(ladIn), .strb(strb), .nibIdx(nibIdx),
    .kind(kind), .regRdata(regRdata), .ladOut(ladOut), .ladOe(ladOe),
    .regAddr(regAddr), .regWdata(regWdata), .sizeCode(regSize),
    .dmaChan(dmaChan), .dmaTc(dmaTc)
  );

endmodule

// File: rtl/lpcTargetChk.sv
module lpcTargetChk (
  input logic       clk,
  input logic       rstN,
  input logic       frameIn,
  input logic [3:0] ladOut,
  input logic       ladOe,
  input logic       regReq,
  input logic       regAck,
  input logic [1:0] regSize
);

  // R11
  abort_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameIn |=> (!ladOe && !regReq));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck && !frameIn) |=> regReq);

  // R8
  wait_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    regReq |-> (ladOe && ladOut == 4'h6));

  // R8
  ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regAck && !frameIn) |=> (ladOe && ladOut == 4'h0 && !regReq));

  // R7
  first_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ladOe) |-> (ladOut == 4'h6));

  // R5
  size_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    regSize != 2'b11);

endmodule

bind lpcTarget lpcTargetChk uChk (
  .clk(clk), .rstN(rstN), .frameIn(frameIn), .ladOut(ladOut), .ladOe(ladOe),
  .regReq(regReq), .regAck(regAck), .regSize(regSize)
);

// File: tb/tb_lpcTarget.sv
module tb_lpcTarget;

  typedef struct packed {
    logic [3:0]  startN;
    logic        hasCyc;
    logic [3:0]  cycN;
    logic [31:0] addr;
    logic [3:0]  addrNibs;
    logic        hasChan;
    logic [3:0]  chanN;
    logic        hasSize;
    logic [3:0]  sizeN;
    logic        wr;
    logic [2:0]  nBytes;
    logic [31:0] data;
    logic [3:0]  waitClks;
    logic [1:0]  expKind;
    logic [1:0]  expSize;
  } vecT;

  localparam int NVEC = 10;
  localparam vecT VECS [NVEC] = '{
    '{4'h0,1'b1,4'h0,32'h0000_12A4,4'd4,1'b0,4'h0,1'b0,4'h0,1'b0,3'd1,32'h0000_005C,4'd0,2'd0,2'd0},
    '{4'h0,1'b1,4'h2,32'h0000_80F3,4'd4,1'b0,4'h0,1'b0,4'h0,1'b1,3'd1,32'h0000_00A7,4'd2,2'd0,2'd0},
    '{4'h0,1'b1,4'h4,32'hFEDC_BA98,4'd8,1'b0,4'h0,1'b0,4'h0,1'b0,3'd1,32'h0000_003E,4'd1,2'd1,2'd0},
    '{4'h0,1'b1,4'h6,32'h1234_5678,4'd8,1'b0,4'h0,1'b0,4'h0,1'b1,3'd1,32'h0000_0091,4'd0,2'd1,2'd0},
    '{4'hD,1'b0,4'h0,32'hFFF0_0010,4'd8,1'b0,4'h0,1'b1,4'h2,1'b0,3'd4,32'hDEAD_BEEF,4'd3,2'd2,2'd2},
    '{4'hE,1'b0,4'h0,32'h0000_4000,4'd8,1'b0,4'h0,1'b1,4'h1,1'b1,3'd2,32'h0000_C35A,4'd0,2'd2,2'd1},
    '{4'h0,1'b1,4'h8,32'h0000_0000,4'd0,1'b1,4'hD,1'b1,4'h3,1'b1,3'd4,32'h8765_4321,4'd1,2'd3,2'd2},
    '{4'h0,1'b1,4'hA,32'h0000_0000,4'd0,1'b1,4'h2,1'b1,4'h1,1'b0,3'd2,32'h0000_B00F,4'd2,2'd3,2'd1},
    '{4'h0,1'b1,4'hA,32'h0000_0000,4'd0,1'b1,4'h7,1'b1,4'h3,1'b0,3'd4,32'h0A1B_2C3D,4'd0,2'd3,2'd2},
    '{4'hD,1'b0,4'h0,32'h0000_0001,4'd8,1'b0,4'h0,1'b1,4'h0,1'b0,3'd1,32'h0000_0077,4'd0,2'd2,2'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameIn = 1'b0;
  logic [3:0]  ladHost = 4'h0;
  logic [3:0]  ladOut;
  logic        ladOe;
  logic        regReq;
  logic        regWrite;
  logic [1:0]  regKind;
  logic [31:0] regAddr;
  logic [1:0]  regSize;
  logic [31:0] regWdata;
  logic [31:0] regRdata = 32'h0;
  logic        regAck = 1'b0;
  logic [2:0]  dmaChan;
  logic        dmaTc;

  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  lpcTarget dut (
    .clk(clk), .rstN(rstN), .frameIn(frameIn), .ladIn(ladHost),
    .ladOut(ladOut), .ladOe(ladOe), .regReq(regReq), .regWrite(regWrite),
    .regKind(regKind), .regAddr(regAddr), .regSize(regSize),
    .regWdata(regWdata), .regRdata(regRdata), .regAck(regAck),
    .dmaChan(dmaChan), .dmaTc(dmaTc)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] nib(input logic [31:0] w, input int k);
    return w[4*k +: 4];
  endfunction

  // drive one host clock; LAD must be undriven by the target beforehand (R7)
  task automatic send(input logic f, input logic [3:0] n, input bit chkIdle);
    if (chkIdle) chk(ladOe == 1'b0, "R7 target drove LAD in host phase", 32'(ladOe), 32'h0);
    frameIn = f;
    ladHost = n;
    @(negedge clk);
    frameIn = 1'b0;
  endtask

  task automatic runVec(input vecT v, input bit aborting);
    string tag;
    logic [31:0] expAddr;
    tag = (v.expKind == 2'd0) ? "R2" : (v.expKind == 2'd1) ? "R3" :
          (v.expKind == 2'd2) ? "R4" : "R5";
    expAddr = v.hasChan ? 32'h0 : v.addr;
    send(1'b1, v.startN, !aborting);
    if (aborting) chk(!ladOe && !regReq, "R11 abort did not release", {30'h0, ladOe, regReq}, 32'h0);
    if (v.hasCyc) send(1'b0, v.cycN, 1'b1);
    for (int i = 0; i < int'(v.addrNibs); i++) send(1'b0, nib(v.addr, int'(v.addrNibs) - 1 - i), 1'b1);
    if (v.hasChan) send(1'b0, v.chanN, 1'b1);
    if (v.hasSize) send(1'b0, v.sizeN, 1'b1);
    if (v.wr) for (int i = 0; i < 2 * int'(v.nBytes); i++) send(1'b0, nib(v.data, i), 1'b1);
    send(1'b0, 4'hF, 1'b1);
    send(1'b0, 4'hF, 1'b1);
    // third clock after the header: long-wait SYNC with request (R7, R8)
    chk(ladOe && ladOut == 4'h6 && regReq, "R8 first sync", {27'h0, ladOe, ladOut}, 32'h16);
    chk(regAddr == expAddr, {tag, " address"}, regAddr, expAddr);
    chk(regKind == v.expKind, {tag, " kind"}, 32'(regKind), 32'(v.expKind));
    chk(regWrite == v.wr, {tag, " direction"}, 32'(regWrite), 32'(v.wr));
    chk(regSize == v.expSize, {tag, " size"}, 32'(regSize), 32'(v.expSize));
    if (v.hasChan) chk({dmaTc, dmaChan} == v.chanN, "R5 channel", 32'({dmaTc, dmaChan}), 32'(v.chanN));
    if (v.wr) chk(regWdata == v.data, "R6 write data", regWdata, v.data);
    for (int i = 0; i < int'(v.waitClks); i++) begin
      @(negedge clk);
      chk(regReq && ladOe && ladOut == 4'h6, "R8 long wait", {27'h0, regReq, ladOut}, 32'h16);
    end
    regRdata = v.wr ? 32'h0 : v.data;
    regAck = 1'b1;
    @(negedge clk);
    regAck = 1'b0;
    chk(ladOe && ladOut == 4'h0 && !regReq, "R8 ready sync", {27'h0, regReq, ladOut}, 32'h0);
    if (!v.wr) begin
      for (int b = 0; b < int'(v.nBytes); b++) begin
        if (b > 0 && v.expKind == 2'd3) begin
          @(negedge clk);
          chk(ladOe && ladOut == 4'h0, "R9 inter-byte sync", 32'(ladOut), 32'h0);
        end
        for (int n = 0; n < 2; n++) begin
          @(negedge clk);
          chk(ladOe && ladOut == nib(v.data, 2 * b + n), "R9 read nibble", 32'(ladOut), 32'(nib(v.data, 2 * b + n)));
        end
      end
    end
    @(negedge clk);
    chk(ladOe && ladOut == 4'hF, "R10 turnaround ones", {27'h0, ladOe, ladOut}, 32'h1F);
    @(negedge clk);
    chk(!ladOe, "R10 turnaround release", 32'(ladOe), 32'h0);
  endtask

  // header of a memory read up to the point where the target waits
  task automatic memReadToWait();
    send(1'b1, 4'h0, 1'b1);
    send(1'b0, 4'h4, 1'b1);
    for (int i = 0; i < 8; i++) send(1'b0, 4'h5, 1'b1);
    send(1'b0, 4'hF, 1'b1);
    send(1'b0, 4'hF, 1'b1);
  endtask

  initial begin
    #(20 * 100000);
    chk(1'b0, "R1 watchdog expired", 32'h0, 32'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ladOe && !regReq, "R1 in reset", {30'h0, ladOe, regReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!ladOe && !regReq, "R1 after reset", {30'h0, ladOe, regReq}, 32'h0);

    // table walk; each new start lands on the previous cycle's release clock (R10)
    for (int k = 0; k < NVEC; k++) runVec(VECS[k], 1'b0);

    // R11: abort while the target waits for the local port
    memReadToWait();
    chk(ladOe && regReq, "R11 setup wait", {30'h0, ladOe, regReq}, 32'h3);
    runVec(VECS[1], 1'b1);

    // R11: abort in the middle of the address phase
    send(1'b1, 4'h0, 1'b1);
    send(1'b0, 4'h0, 1'b1);
    send(1'b0, 4'h9, 1'b1);
    send(1'b0, 4'h9, 1'b1);
    runVec(VECS[0], 1'b0);

    // R12: unknown start code, then unknown cycle type
    send(1'b1, 4'h3, 1'b1);
    for (int i = 0; i < 8; i++) send(1'b0, 4'h0, 1'b1);
    chk(!ladOe && !regReq, "R12 bad start", {30'h0, ladOe, regReq}, 32'h0);
    send(1'b1, 4'h0, 1'b1);
    send(1'b0, 4'hC, 1'b1);
    for (int i = 0; i < 6; i++) send(1'b0, 4'hF, 1'b1);
    chk(!ladOe && !regReq, "R12 bad cycle type", {30'h0, ladOe, regReq}, 32'h0);
    runVec(VECS[3], 1'b0);

    // R1: reset in the middle of a wait
    memReadToWait();
    rstN = 1'b0;
    @(negedge clk);
    chk(!ladOe && !regReq, "R1 reset during wait", {30'h0, ladOe, regReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    runVec(VECS[7], 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule